// File: doc/BRIEF.md
# Bus Hold and Backoff Controller

This block decides who owns the external bus of a processor. The core hands it one cycle request at a time, either a single transfer or a burst of `2**BEAT_W` beats. The block then runs that cycle on the bus and reports every beat it accepts. It can give the bus up in two ways. The first is a polite hold request: the cycle in flight runs to its end, then the bus outputs float and an acknowledge is raised. The second is an active-low backoff: the bus floats on the next clock with no acknowledge, and any ready strobe in that clock is discarded. The aborted cycle is then run again from its first beat once the backoff is released.

Both release paths drive the same float control. The bus-request output is not part of the floated group, so it stays valid while another master owns the bus. Reset is synchronous and active high. A hold request is honoured while reset is still asserted.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While `rst` is high, one clock later the block is held (`hold_ack`=1 and `bus_float`=1) if `hold_req` is high. Otherwise it is idle, with `hold_ack`, `bus_float` and `addr_en` all 0.
- R2: When idle, `req_take` is 1 in any clock where `req_valid`=1, `hold_req`=0 and `backoff_n`=1. In the next clock `addr_en`=1 and a cycle starts. `addr_en` is 1 only while a cycle is running on the bus.
- R3: A single cycle (`req_burst`=0) completes when `rdy_n`=0. In that clock `beat_ack` and `cyc_done` are both 1, and in the next clock `addr_en` is 0.
- R4: A burst (`req_burst`=1) advances one beat on each clock with `brdy_n`=0. During a burst, `bus_addr` carries the request address with its low `BEAT_W` bits replaced by the beat index, starting at 0. `cyc_done` rises on the last beat, index `2**BEAT_W-1`. A single cycle puts the request address on `bus_addr` unchanged.
- R5: A hold request that arrives during a cycle does not stop it. `addr_en` stays 1 until the cycle completes. In the clock after completion, `bus_float` and `hold_ack` both go to 1 in the same clock.
- R6: A hold request seen while idle gives `bus_float`=1 and `hold_ack`=1 on the next clock. Both remain until `hold_req` is seen low, and both return to 0 on the clock after that.
- R7: One clock after `backoff_n` is seen low, in any state including idle, the outputs are `bus_float`=1, `hold_ack`=0 and `addr_en`=0.
- R8: While `backoff_n` is 0, `beat_ack` and `cyc_done` are 0 whatever `rdy_n` and `brdy_n` do.
- R9: Once `backoff_n` is seen high again with `hold_req` low, an aborted cycle restarts on the next clock. It uses the same address and type, and a burst begins again from beat 0.
- R10: If `hold_req` is high when a backoff ends, the block enters the held state first. The aborted cycle restarts only after the hold is released.
- R11: `bus_req` equals `req_valid`, OR a cycle running, OR an aborted cycle awaiting restart. It is never forced low by floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core has a cycle to run |
| req_addr | input | ADDR_W | Address of the requested cycle |
| req_burst | input | 1 | 1 = burst cycle, 0 = single transfer |
| req_take | output | 1 | Request accepted this clock |
| hold_req | input | 1 | Another master asks for the bus |
| backoff_n | input | 1 | Abort and float immediately, active low |
| rdy_n | input | 1 | Single-transfer ready, active low |
| brdy_n | input | 1 | Burst beat ready, active low |
| bus_addr | output | ADDR_W | Address of the current beat |
| addr_en | output | 1 | A cycle is running on the bus |
| bus_float | output | 1 | Tri-state the floatable bus outputs |
| hold_ack | output | 1 | Hold acknowledge |
| beat_ack | output | 1 | A beat of data was accepted |
| cyc_done | output | 1 | Cycle finished, to the core |
| bus_req | output | 1 | Bus wanted; never floated |

## Verification
The bench builds the block with `ADDR_W`=12 and `BEAT_W`=2, which gives four-beat bursts. With bursts that short, a backoff that lands on the first, a middle or the last beat occurs often under random stimulus. That makes both restart-from-beat-0 and ready-versus-backoff collisions on the final beat frequent. The 12-bit address keeps the beat-index substitution in `bus_addr` easy to read in failure lines.

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_burst,
  output logic              req_take,
  input  logic              hold_req,
  input  logic              backoff_n,
  input  logic              rdy_n,
  input  logic              brdy_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              addr_en,
  output logic              bus_float,
  output logic              hold_ack,
  output logic              beat_ack,
  output logic              cyc_done,
  output logic              bus_req
);
  localparam int S_IDLE  = 0;
  localparam int S_ACT   = 1;
  localparam int S_HPEND = 2;
  localparam int S_HELD  = 3;
  localparam int S_BOFF  = 4;
  localparam logic [4:0] ONE_IDLE = 5'd1 << S_IDLE;
  localparam logic [4:0] ONE_HELD = 5'd1 << S_HELD;
  localparam logic [BEAT_W-1:0] LAST = '1;

  logic [4:0]        st, st_nx;
  logic [ADDR_W-1:0] cyc_addr;
  logic              cyc_burst;
  logic [BEAT_W-1:0] beat;
  logic              pend;
  logic              in_cyc, floated, restart;

  assign in_cyc    = st[S_ACT] | st[S_HPEND];
  assign floated   = st[S_HELD] | st[S_BOFF];
  assign restart   = backoff_n & floated & ~hold_req & pend;

  assign addr_en   = in_cyc;
  assign bus_float = floated;
  assign hold_ack  = st[S_HELD];
  assign beat_ack  = in_cyc & backoff_n & (cyc_burst ? ~brdy_n : ~rdy_n);
  assign cyc_done  = beat_ack & (~cyc_burst | (beat == LAST));
  assign req_take  = st[S_IDLE] & req_valid & ~hold_req & backoff_n;
  assign bus_req   = req_valid | in_cyc | pend;
  assign bus_addr  = cyc_burst ? {cyc_addr[ADDR_W-1:BEAT_W], beat} : cyc_addr;

  always_comb begin
    st_nx = '0;
    if (!backoff_n)
      st_nx[S_BOFF] = 1'b1;
    else if (in_cyc) begin
      if (cyc_done) st_nx[hold_req ? S_HELD : S_IDLE] = 1'b1;
      else          st_nx[hold_req ? S_HPEND : S_ACT] = 1'b1;
    end else if (floated) begin
      if (hold_req)  st_nx[S_HELD] = 1'b1;
      else if (pend) st_nx[S_ACT]  = 1'b1;
      else           st_nx[S_IDLE] = 1'b1;
    end else if (hold_req)
      st_nx[S_HELD] = 1'b1;
    else if (req_valid)
      st_nx[S_ACT] = 1'b1;
    else
      st_nx[S_IDLE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= hold_req ? ONE_HELD : ONE_IDLE;
      pend      <= 1'b0;
      beat      <= '0;
      cyc_addr  <= '0;
      cyc_burst <= 1'b0;
    end else begin
      st <= st_nx;
      if (req_take) begin
        cyc_addr  <= req_addr;
        cyc_burst <= req_burst;
      end
      if (req_take || restart)      beat <= '0;
      else if (beat_ack && !cyc_done) beat <= beat + 1'b1;
      if (!backoff_n && in_cyc) pend <= 1'b1;
      else if (restart)         pend <= 1'b0;
    end
  end

  logic seen;
  always_ff @(posedge clk) seen <= ~rst;

  AST_BOFF_FLOATS: assert property (@(posedge clk) disable iff (rst || !seen)
    !backoff_n |=> bus_float && !hold_ack && !addr_en); // R7
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst || !seen)
    cyc_done |=> !addr_en); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst || !seen)
    addr_en && $past(addr_en) && !$past(beat_ack) |-> $stable(bus_addr)); // R4
  AST_ACK_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst || !seen)
    $rose(hold_ack) |-> $past(!addr_en || cyc_done)); // R5
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst || !seen)
    $fell(hold_ack) |-> $past(!hold_req || !backoff_n)); // R6
endmodule

// File: tb/bus_hold_ctrl_bench.sv
module bus_hold_ctrl_bench;
  localparam int AW = 12;
  localparam int BW = 2;
  localparam logic [BW-1:0] LASTB = '1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, req_valid, req_burst, hold_req, backoff_n, rdy_n, brdy_n;
  logic [AW-1:0] req_addr;
  logic [AW-1:0] bus_addr;
  logic req_take, addr_en, bus_float, hold_ack, beat_ack, cyc_done, bus_req;

  bus_hold_ctrl #(.ADDR_W(AW), .BEAT_W(BW)) u_bus_hold_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_burst(req_burst), .req_take(req_take), .hold_req(hold_req),
    .backoff_n(backoff_n), .rdy_n(rdy_n), .brdy_n(brdy_n),
    .bus_addr(bus_addr), .addr_en(addr_en), .bus_float(bus_float),
    .hold_ack(hold_ack), .beat_ack(beat_ack), .cyc_done(cyc_done),
    .bus_req(bus_req));

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;

  // model: 0 idle, 1 running, 2 held, 3 backed off
  int            m_st = 0;
  logic [AW-1:0] m_addr = '0;
  logic          m_burst = 1'b0;
  logic          m_pend = 1'b0;
  logic [BW-1:0] m_beat = '0;
  bit            m_valid = 1'b0;
  bit            m_took = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr();
    return m_burst ? {m_addr[AW-1:BW], m_beat} : m_addr;
  endfunction

  task automatic model_step();
    logic ok, done, take;
    ok   = (m_st == 1) && backoff_n && (m_burst ? !brdy_n : !rdy_n);
    done = ok && (!m_burst || m_beat == LASTB);
    take = (m_st == 0) && req_valid && !hold_req && backoff_n;
    if (m_valid) begin
      chk("R7 bus_float", bus_float, (m_st == 2 || m_st == 3));
      chk("R6 hold_ack", hold_ack, (m_st == 2));
      chk("R2 addr_en", addr_en, (m_st == 1));
      if (m_st == 1) chk("R4 bus_addr", bus_addr, exp_addr());
      chk("R8 beat_ack", beat_ack, ok);
      chk("R3 cyc_done", cyc_done, done);
      chk("R2 req_take", req_take, take);
      chk("R11 bus_req", bus_req, (req_valid || m_st == 1 || m_pend));
    end
    m_took = take;
    if (rst) begin
      m_st = hold_req ? 2 : 0; m_pend = 1'b0; m_beat = '0; m_valid = 1'b1;
    end else if (!backoff_n) begin
      if (m_st == 1) m_pend = 1'b1;
      m_st = 3;
    end else begin
      case (m_st)
        0: if (hold_req) m_st = 2;
           else if (req_valid) begin
             m_st = 1; m_addr = req_addr; m_burst = req_burst; m_beat = '0;
           end
        1: if (done) m_st = hold_req ? 2 : 0;
           else if (ok) m_beat = m_beat + 1'b1;
        default: if (hold_req) m_st = 2;
                 else if (m_pend) begin m_st = 1; m_pend = 1'b0; m_beat = '0; end
                 else m_st = 0;
      endcase
    end
  endtask

  task automatic cyc();
    #1;
    model_step();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; hold_req = 1; backoff_n = 1; rdy_n = 1; brdy_n = 1;
    req_valid = 0; req_addr = '0; req_burst = 0;
    @(negedge clk);
    cyc(); cyc();
    chk("R1 hold acknowledged in reset", hold_ack, 1);
    chk("R1 floated in reset", bus_float, 1);
    hold_req = 0; cyc();
    chk("R1 idle in reset", {hold_ack, bus_float, addr_en}, 0);
    rst = 0; cyc();

    req_valid = 1; req_addr = 12'h3A5; req_burst = 0; cyc(); req_valid = 0;
    hold_req = 1; cyc(); cyc();
    chk("R5 cycle runs on under hold", addr_en, 1);
    chk("R5 no acknowledge yet", hold_ack, 0);
    rdy_n = 0; cyc(); rdy_n = 1;
    chk("R5 float with acknowledge", {bus_float, hold_ack}, 2'b11);
    cyc(); hold_req = 0; cyc();
    chk("R6 released", {bus_float, hold_ack}, 0);

    backoff_n = 0; cyc(); backoff_n = 1;
    chk("R7 idle backoff floats", {bus_float, hold_ack}, 2'b10);
    cyc();
    chk("R7 bus driven again", bus_float, 0);

    req_valid = 1; req_addr = 12'h7C2; req_burst = 1; cyc(); req_valid = 0;
    brdy_n = 0; cyc(); cyc();
    backoff_n = 0; cyc();
    chk("R9 aborted burst", addr_en, 0);
    backoff_n = 1; brdy_n = 1; cyc();
    chk("R9 restart", addr_en, 1);
    chk("R9 restart address beat 0", bus_addr, 12'h7C0);
    brdy_n = 0; repeat (4) cyc(); brdy_n = 1;
    chk("R4 burst complete", addr_en, 0);

    req_valid = 1; req_addr = 12'h155; req_burst = 0; cyc(); req_valid = 0;
    backoff_n = 0; cyc(); hold_req = 1; cyc(); backoff_n = 1; cyc();
    chk("R10 hold before restart", {hold_ack, addr_en}, 2'b10);
    hold_req = 0; cyc();
    chk("R10 restart after hold", addr_en, 1);
    chk("R10 same address", bus_addr, 12'h155);
    rdy_n = 0; cyc(); rdy_n = 1; cyc();

    for (int i = 0; i < 4000; i++) begin
      if (!req_valid || m_took) begin
        req_valid = ($urandom % 3) != 0;
        req_addr  = AW'($urandom);
        req_burst = 1'($urandom);
      end
      if ($urandom % 16 == 0) hold_req = ~hold_req;
      backoff_n = ($urandom % 8) != 0;
      rdy_n  = 1'($urandom);
      brdy_n = 1'($urandom);
      rst = ($urandom % 500) == 0;
      if (rst) req_valid = 0;
      cyc();
    end
    rst = 0;
    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule